// File: doc/BRIEF.md
# Programmable Counter/Timer Channel

This block is one channel of a counter/timer. Software programs it through a single byte-wide write port that carries three kinds of byte: control words, time constants and an interrupt vector. An 8-bit down-counter is loaded from a time-constant register. It is decremented either by a prescaled system clock (timer mode) or by active edges on a trigger input (counter mode). When it reaches zero it reloads itself and emits a one-clock pulse on its zero-count output. It can also raise an interrupt request at the same moment.

A read port shows the live down-counter value at all times. The interrupt vector output combines the upper bits from the last vector byte with a fixed channel identifier. A device wrapper can therefore tell which channel asked for service.

Top module: `tmr_channel`

## Requirements
- R1: After reset the channel is stopped, `rd_data` reads 0, `zc_pulse` and `irq_req` are low, and `vec_out` equals `{5'b0, CHAN_ID[1:0], 1'b0}`.
- R2: A written byte with bit 0 = 0 is a vector byte (unless a time constant is pending). Bits 7:3 are kept, and `vec_out` becomes `{byte[7:3], CHAN_ID[1:0], 1'b0}`.
- R3: A control byte (bit 0 = 1) with bit 2 = 1 makes the next write load the time constant, whatever its bit 0 holds. That write leaves `vec_out` unchanged.
- R4: In timer mode (bit 6 = 0) the counter steps once per 16 clocks when bit 5 = 0, or once per 256 clocks when bit 5 = 1. The zero-count period is therefore prescale × time constant clocks.
- R5: In timer mode with bit 3 = 0, a time constant written while stopped starts counting at once. The first zero count comes prescale × TC clocks after the write edge.
- R6: In timer mode with bit 3 = 1, the time-constant write arms the channel only. Counting starts at the first active trigger edge, and the first zero count comes prescale × TC clocks after the edge is sampled.
- R7: In counter mode (bit 6 = 1) each active edge of `trg_in` decrements the counter. Bit 4 = 1 selects rising edges and bit 4 = 0 selects falling edges. Edges of the other polarity do nothing.
- R8: On reaching zero the counter reloads from the time-constant register. `zc_pulse` is then high for exactly one clock.
- R9: `irq_req` pulses together with `zc_pulse` only when control bit 7 = 1.
- R10: A time constant of 0 acts as 256.
- R11: A control byte with bit 1 = 1 stops the channel. The counter holds and no zero count occurs until a new time constant is written.
- R12: A time constant written while the channel runs changes only the reload value. The count in progress completes first.
- R13: `rd_data` returns the current down-counter value, with 256 reading as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_data | input | 8 | Control, time-constant or vector byte |
| trg_in | input | 1 | Counter clock / timer trigger input |
| rd_data | output | 8 | Current down-counter value |
| zc_pulse | output | 1 | One-clock zero-count pulse |
| irq_req | output | 1 | Interrupt request pulse |
| vec_out | output | 8 | Interrupt vector with channel identifier |

## Verification
The assertions assume that `trg_in` is synchronous to `clk` and that an active edge is never followed by another active edge in the next cycle. Under that assumption the zero-count pulse cannot be stretched. They also assume `wr_en` is a single-cycle strobe. The bench changes `trg_in` and the write port only at falling clock edges. It keeps trigger transitions at least three clocks apart and never issues back-to-back writes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 8;
    localparam int PRE_W  = 8;

    typedef struct packed {
        logic irq_en;
        logic cnt_mode;
        logic div256;
        logic rise_edge;
        logic trig_start;
    } mode_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ARMED = 2'd1,
        PH_RUN   = 2'd2
    } phase_t;

    function automatic mode_t mode_from_byte(input logic [BYTE_W-1:0] b);
        mode_t m;
        m.irq_en     = b[7];
        m.cnt_mode   = b[6];
        m.div256     = b[5];
        m.rise_edge  = b[4];
        m.trig_start = b[3];
        return m;
    endfunction

    function automatic logic [CNT_W:0] tc_expand(input logic [CNT_W-1:0] v);
        return (v == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, v};
    endfunction

endpackage

// File: rtl/tmr_edge_detect.sv
module tmr_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    input  logic rise_sel,
    output logic edge_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        prev_q <= sig_in;
    end

    always_comb begin
        if (rst)
            edge_o = 1'b0;
        else if (rise_sel)
            edge_o = sig_in & ~prev_q;
        else
            edge_o = ~sig_in & prev_q;
    end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  logic div256,
    output logic tick
);
    localparam logic [W-1:0] LIM_LONG  = {W{1'b1}};
    localparam logic [W-1:0] LIM_SHORT = W'(15);

    logic [W-1:0] cnt_q;
    logic [W-1:0] lim;

    assign lim  = div256 ? LIM_LONG : LIM_SHORT;
    assign tick = en && (cnt_q >= lim);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (en)
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end

    // R4: every prescaler tick restarts the division from zero
    assert_tick_restart_R4: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_downcounter.sv
module tmr_downcounter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W:0]   load_val,
    input  logic         dec,
    input  logic [W:0]   reload_val,
    output logic [W:0]   count,
    output logic         zero_hit
);
    localparam logic [W:0] FULL = {1'b1, {W{1'b0}}};
    localparam logic [W:0] ONE  = (W+1)'(1);

    assign zero_hit = dec && !load && (count == ONE);

    always_ff @(posedge clk) begin
        if (rst)
            count <= FULL;
        else if (load)
            count <= load_val;
        else if (dec)
            count <= (count == ONE) ? reload_val : count - 1'b1;
    end

    // R10: the counter never holds zero; a zero constant is carried as full scale
    assert_never_zero_R10: assert property (@(posedge clk) disable iff (rst)
        count != '0);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CHAN_ID = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              trg_in,
    output logic [BYTE_W-1:0] rd_data,
    output logic              zc_pulse,
    output logic              irq_req,
    output logic [BYTE_W-1:0] vec_out
);
    localparam int VHI_W = BYTE_W - 3;
    localparam logic [1:0] CID = CHAN_ID[1:0];

    mode_t            mode_q;
    phase_t           phase_q;
    logic             tc_pending_q;
    logic [CNT_W-1:0] tc_q;
    logic [VHI_W-1:0] vec_hi_q;

    logic is_tc_wr, is_ctrl_wr, is_vec_wr;
    logic trg_edge, pre_tick, cnt_load, cnt_dec, zero_hit;
    logic [CNT_W:0] cnt_val;

    assign is_tc_wr   = wr_en && tc_pending_q;
    assign is_ctrl_wr = wr_en && !tc_pending_q && wr_data[0];
    assign is_vec_wr  = wr_en && !tc_pending_q && !wr_data[0];
    assign cnt_load   = is_tc_wr && (phase_q == PH_IDLE);

    tmr_edge_detect u_edge (
        .clk      (clk),
        .rst      (rst),
        .sig_in   (trg_in),
        .rise_sel (mode_q.rise_edge),
        .edge_o   (trg_edge)
    );

    tmr_prescaler #(.W(PRE_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .clr    (phase_q != PH_RUN),
        .en     ((phase_q == PH_RUN) && !mode_q.cnt_mode),
        .div256 (mode_q.div256),
        .tick   (pre_tick)
    );

    assign cnt_dec = (phase_q == PH_RUN) && (mode_q.cnt_mode ? trg_edge : pre_tick);

    tmr_downcounter #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load       (cnt_load),
        .load_val   (tc_expand(wr_data)),
        .dec        (cnt_dec),
        .reload_val (tc_expand(tc_q)),
        .count      (cnt_val),
        .zero_hit   (zero_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q       <= '0;
            phase_q      <= PH_IDLE;
            tc_pending_q <= 1'b0;
            tc_q         <= '0;
            vec_hi_q     <= '0;
            zc_pulse     <= 1'b0;
            irq_req      <= 1'b0;
        end else begin
            zc_pulse <= zero_hit;
            irq_req  <= zero_hit && mode_q.irq_en;
            if (is_ctrl_wr) begin
                mode_q       <= mode_from_byte(wr_data);
                tc_pending_q <= wr_data[2];
                if (wr_data[1])
                    phase_q <= PH_IDLE;
            end else if (is_vec_wr) begin
                vec_hi_q <= wr_data[BYTE_W-1:3];
            end else if (is_tc_wr) begin
                tc_q         <= wr_data;
                tc_pending_q <= 1'b0;
                if (phase_q == PH_IDLE)
                    phase_q <= (!mode_q.cnt_mode && mode_q.trig_start) ? PH_ARMED : PH_RUN;
            end else if (phase_q == PH_ARMED && trg_edge) begin
                phase_q <= PH_RUN;
            end
        end
    end

    assign rd_data = cnt_val[CNT_W-1:0];
    assign vec_out = {vec_hi_q, CID, 1'b0};

    // R8: the zero-count pulse is one clock wide
    assert_zc_single_R8: assert property (@(posedge clk) disable iff (rst)
        zc_pulse |=> !zc_pulse);

    // R9: an interrupt request only ever accompanies a zero count
    assert_irq_with_zc_R9: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> zc_pulse);

    // R11: while stopped the counter holds unless a constant is loaded
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && !cnt_load) |=> $stable(cnt_val));

    // R3: a time-constant byte never reaches the vector
    assert_tc_not_vector_R3: assert property (@(posedge clk) disable iff (rst)
        is_tc_wr |=> $stable(vec_out));
endmodule

// File: tb/tmr_channel_tb.sv
module tmr_channel_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       trg_in = 1'b0;
    logic [7:0] rd_data, vec_out;
    logic       zc_pulse, irq_req;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    int exp_q[$];
    logic irq_exp = 1'b0;
    logic zc_prev = 1'b0;
    bit done = 0;

    tmr_channel #(.CHAN_ID(2)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .trg_in(trg_in),
        .rd_data(rd_data), .zc_pulse(zc_pulse), .irq_req(irq_req), .vec_out(vec_out)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    task automatic wr(input logic [7:0] d, output int cw);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; cw = cyc + 1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // scoreboard monitor: each zero-count pulse pops the expected cycle
    always @(negedge clk) begin
        if (!rst && zc_pulse) begin
            if (exp_q.size() == 0) begin
                check("R8/R11 unexpected zero count", cyc, -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check("R4/R8 zero-count cycle", cyc, e);
                check("R9 irq with zero count", int'(irq_req), int'(irq_exp));
            end
            check("R8 pulse width", int'(zc_prev), 0);
        end
        zc_prev <= zc_pulse;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            check("watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int cw, e, r1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 rd_data", rd_data, 0);
        check("R1 zc", int'(zc_pulse), 0);
        check("R1 irq", int'(irq_req), 0);
        check("R1 vec", vec_out, 8'h04);

        // R2 vector byte
        wr(8'hA8, cw);
        check("R2 vector", vec_out, 8'hAC);

        // R5/R9/R13: timer /16, TC=3, irq enabled
        irq_exp = 1'b1;
        wr(8'h85, cw);
        wr(8'h03, cw);
        exp_q.push_back(cw + 48);
        exp_q.push_back(cw + 96);
        check("R13 read after load", rd_data, 3);
        wait_until(cw + 20);
        check("R13 read after one step", rd_data, 2);
        check("R3 tc byte left vector", vec_out, 8'hAC);
        wait_until(cw + 100);
        wr(8'h03, cw);           // R11 stop
        r1 = rd_data;
        repeat (200) @(negedge clk);
        check("R11 counter holds", rd_data, r1);
        check("R5 queue drained", exp_q.size(), 0);

        // R4: /256, TC=2, no irq
        irq_exp = 1'b0;
        wr(8'h25, cw);
        wr(8'h02, cw);
        exp_q.push_back(cw + 512);
        exp_q.push_back(cw + 1024);
        wait_until(cw + 1030);
        wr(8'h03, cw);
        check("R4 queue drained", exp_q.size(), 0);

        // R10: TC=0 means 256
        wr(8'h07, cw);
        wr(8'h00, cw);
        check("R10 reads as zero", rd_data, 0);
        exp_q.push_back(cw + 4096);
        wait_until(cw + 4100);
        wr(8'h03, cw);
        check("R10 queue drained", exp_q.size(), 0);

        // R6: trigger-started timer, rising edge, TC=2
        wr(8'h1F, cw);
        wr(8'h02, cw);
        repeat (60) @(negedge clk);
        check("R6 no start before trigger", rd_data, 2);
        trg_in = 1'b1; e = cyc + 1;
        exp_q.push_back(e + 32);
        exp_q.push_back(e + 64);
        wait_until(e + 70);
        wr(8'h03, cw);
        check("R6 queue drained", exp_q.size(), 0);

        // R7: counter mode, falling edges, TC=3
        wr(8'h47, cw);
        wr(8'h03, cw);
        for (int k = 0; k < 3; k++) begin
            repeat (3) @(negedge clk);
            trg_in = 1'b0; e = cyc + 1;
            if (k == 2) exp_q.push_back(e);
            repeat (3) @(negedge clk);
            trg_in = 1'b1;     // rising edge must be ignored
            if (k == 0) begin
                @(negedge clk);
                check("R7 rising edge ignored", rd_data, 2);
            end
        end
        repeat (5) @(negedge clk);
        check("R7 reloaded after third edge", rd_data, 3);
        check("R7 queue drained", exp_q.size(), 0);
        wr(8'h03, cw);

        // R12: new constant while running applies at next reload
        wr(8'h07, cw);
        wr(8'h02, cw);
        e = cw;
        exp_q.push_back(e + 32);
        exp_q.push_back(e + 32 + 64);
        wait_until(e + 8);
        wr(8'h05, cw);
        wr(8'h04, cw);
        check("R3 tc byte left vector", vec_out, 8'hAC);
        check("R12 count in progress kept", rd_data, 2);
        wait_until(e + 100);
        wr(8'h03, cw);
        check("R12 queue drained", exp_q.size(), 0);

        repeat (20) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule